// File: doc/BRIEF.md
# Serial Receiver with Mid-Start Validation

This block is the receive half of an asynchronous serial port. A free-running enable, `tick16`, pulses sixteen times per bit period and paces the receiver. The serial line passes through a two-flop synchronizer. The receiver then watches the synchronized level on tick cycles only. When the level falls, it counts half a bit period and looks at the line again. If the line is back high, the event was noise, and the receiver returns to waiting without producing a character. If the line is still low, the receiver takes eight data bits, least significant first, and one stop bit, each sampled sixteen ticks after the previous one.

A finished character is copied into an 8-bit holding register and a data-ready flag is raised. The host takes the character by pulsing `rd_strobe`, which drops data-ready and the overrun flag at that clock edge. A three-bit status output carries data-ready, overrun and framing error.

The state machine has four states. **IDLE** moves to **START** on a tick where the previous tick sample was 1 and the current one is 0. **START** moves on the 8th tick: to **DATA** if the line reads 0, or back to **IDLE** if it reads 1 (false start). **DATA** moves to **STOP** after the 16th tick of the 8th data bit. **STOP** moves to **IDLE** on its 16th tick, and that move loads the holding register.

Top module: `serrx_top`

## Requirements
- R1: The serial input reaches the receiver only through a two-stage synchronizer, and the state machine advances only in cycles where `tick16` is 1.
- R2: A low level that has returned high by the 8th tick after the falling edge is dropped as a false start. No character is produced, and data-ready stays as it was.
- R3: After a valid start, 8 data bits are sampled every 16 ticks, starting 16 ticks after the start-bit check. The first bit received lands in `rd_data[0]`.
- R4: When the stop bit is sampled, the assembled byte is copied to `rd_data` and `line_stat[0]` (data-ready) becomes 1 at the next edge.
- R5: A clock edge with `rd_strobe` at 1 and no character completing clears `line_stat[0]` and `line_stat[1]`.
- R6: `line_stat[2]` (framing error) is set to 1 when the stop-bit sample is 0 and to 0 when it is 1. It is updated with every character and is not cleared by a read.
- R7: If a character completes while data-ready is 1 and `rd_strobe` is 0, `rd_data` is overwritten with the new byte and `line_stat[1]` (overrun) becomes 1.
- R8: If a character completes in the same cycle as a read, the load wins: data-ready is 1 afterwards and overrun is 0.
- R9: During and right after reset, `line_stat` is 3'b000 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd_in | input | 1 | Serial input line, idles high |
| rd_strobe | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Holding register contents |
| line_stat | output | 3 | {framing error, overrun, data-ready} |

## Verification
Two events can land on the same clock edge: a character finishing its stop bit and the host reading the holding register. The bench holds `rd_strobe` high for the whole of a character, so the stop-bit load is certain to meet a read. It then requires data-ready to rise for exactly one cycle with the new byte and overrun to stay 0. A separate case leaves a character unread while a second one arrives, so the load meets a set data-ready flag with no read. That case must show overrun and the second byte.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // line status bit positions
    localparam int LS_READY = 0;
    localparam int LS_OVR   = 1;
    localparam int LS_FERR  = 2;
    localparam int LS_W     = 3;

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/serrx_fsm.sv
module serrx_fsm
    import serrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    output logic             load,
    output logic [DBITS-1:0] load_data,
    output logic             load_ferr,
    output rx_state_e        state
);

    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam int BW = (DBITS > 2) ? $clog2(DBITS) : 1;
    localparam logic [CW-1:0] T_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] T_MID  = CW'(OSR / 2 - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DBITS - 1);

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    tcnt_q;
    logic [BW-1:0]    bcnt_q;
    logic [DBITS-1:0] shift_q;
    logic             prev_q;

    logic at_mid, at_end;
    assign at_mid = tick && (tcnt_q == T_MID);
    assign at_end = tick && (tcnt_q == T_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick && prev_q && !line) state_d = ST_START;
            ST_START: if (at_mid)                  state_d = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_end && bcnt_q == B_LAST) state_d = ST_STOP;
            ST_STOP:  if (at_end)                  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shift_q <= '0;
            prev_q  <= 1'b1;
        end else if (tick) begin
            prev_q <= line;
            if (state_d != state_q) begin
                tcnt_q <= '0;
                if (state_d == ST_DATA) bcnt_q <= '0;
            end else if (state_q != ST_IDLE) begin
                tcnt_q <= (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
            end
            if (state_q == ST_DATA && at_end) begin
                shift_q <= {line, shift_q[DBITS-1:1]};
                bcnt_q  <= bcnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load      = (state_q == ST_STOP) && at_end;
        load_data = shift_q;
        load_ferr = !line;
        state     = state_q;
    end

endmodule

// File: rtl/serrx_hold.sv
module serrx_hold #(
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DBITS-1:0] load_data,
    input  logic             load_ferr,
    input  logic             rd,
    output logic [DBITS-1:0] data,
    output logic             ready,
    output logic             ovr,
    output logic             ferr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            ferr  <= 1'b0;
        end else if (load) begin
            data  <= load_data;
            ferr  <= load_ferr;
            ready <= 1'b1;
            ovr   <= rd ? 1'b0 : (ovr | ready);
        end else if (rd) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end

endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DBITS = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd_in,
    input  logic             rd_strobe,
    output logic [DBITS-1:0] rd_data,
    output logic [LS_W-1:0]  line_stat
);

    logic             line_s;
    logic             load_pulse;
    logic [DBITS-1:0] load_data;
    logic             load_ferr;
    rx_state_e        fsm_state;
    logic             ready, ovr, ferr;

    serrx_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_in),
        .dout (line_s)
    );

    serrx_fsm #(.OSR(OSR), .DBITS(DBITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .line     (line_s),
        .load     (load_pulse),
        .load_data(load_data),
        .load_ferr(load_ferr),
        .state    (fsm_state)
    );

    serrx_hold #(.DBITS(DBITS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .load_data(load_data),
        .load_ferr(load_ferr),
        .rd       (rd_strobe),
        .data     (rd_data),
        .ready    (ready),
        .ovr      (ovr),
        .ferr     (ferr)
    );

    always_comb begin
        line_stat           = '0;
        line_stat[LS_READY] = ready;
        line_stat[LS_OVR]   = ovr;
        line_stat[LS_FERR]  = ferr;
    end

endmodule

// File: rtl/serrx_chk.sv
module serrx_chk
    import serrx_pkg::*;
#(
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rd_strobe,
    input  logic [DBITS-1:0] rd_data,
    input  logic [LS_W-1:0]  line_stat,
    input  logic             load_pulse,
    input  logic [DBITS-1:0] load_data,
    input  logic             load_ferr,
    input  rx_state_e        fsm_state
);

    assert_idle_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !tick16) |=> fsm_state == ST_IDLE);

    assert_idle_goes_to_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |=> (fsm_state == ST_IDLE || fsm_state == ST_START));

    assert_load_from_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> (fsm_state == ST_STOP && tick16));

    assert_load_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> (line_stat[LS_READY] && rd_data == $past(load_data)));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(rd_data));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !load_pulse) |=> (!line_stat[LS_READY] && !line_stat[LS_OVR]));

    assert_framing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> line_stat[LS_FERR] == $past(load_ferr));

    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && line_stat[LS_READY] && !rd_strobe) |=> line_stat[LS_OVR]);

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && rd_strobe) |=> (line_stat[LS_READY] && !line_stat[LS_OVR]));

endmodule

bind serrx_top serrx_chk #(.DBITS(DBITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .line_stat (line_stat),
    .load_pulse(load_pulse),
    .load_data (load_data),
    .load_ferr (load_ferr),
    .fsm_state (fsm_state)
);

// File: tb/serrx_top_tb_top.sv
module serrx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, tick16, rxd_in, rd_strobe;
    logic [7:0] rd_data;
    logic [2:0] line_stat;

    typedef struct packed {
        logic [7:0] d;
        logic       fe;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    serrx_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .rxd_in   (rxd_in),
        .rd_strobe(rd_strobe),
        .rd_data  (rd_data),
        .line_stat(line_stat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (tick16) k++;
        end
    endtask

    // driver: pushes the expected item, then shifts the frame out
    task automatic send_char(input logic [7:0] d, input logic stop);
        exp_t e;
        e.d  = d;
        e.fe = ~stop;
        exp_q.push_back(e);
        @(negedge clk) rxd_in = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) rxd_in = d[i];
            wait_ticks(16);
        end
        @(negedge clk) rxd_in = stop;
        wait_ticks(16);
        @(negedge clk) rxd_in = 1'b1;
        wait_ticks(6);
    endtask

    task automatic do_read(input string req);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk(line_stat[1:0] == 2'b00, req, "ready/overrun after read", line_stat[1:0], 0);
    endtask

    task automatic glitch(input int low_ticks);
        @(negedge clk) rxd_in = 1'b0;
        wait_ticks(low_ticks);
        @(negedge clk) rxd_in = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        chk(line_stat[0] == 1'b0, "R2", "ready after false start", line_stat[0], 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // tick generator
    initial begin
        tick16 = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    // monitor: a new character shows as a rise of ready or of overrun
    initial begin
        logic pdr, pov;
        exp_t e;
        pdr = 1'b0;
        pov = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if ((line_stat[0] && !pdr) || (line_stat[1] && !pov)) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected character", rd_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e.d, "R3", "data byte", rd_data, e.d);
                    chk(line_stat[2] == e.fe, "R6", "framing flag", line_stat[2], e.fe);
                end
            end
            pdr = line_stat[0];
            pov = line_stat[1];
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        rxd_in    = 1'b1;
        rd_strobe = 1'b0;
        repeat (5) @(negedge clk);
        chk(line_stat == 3'b000, "R9", "status in reset", line_stat, 0);
        chk(rd_data == 8'h00, "R9", "data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_stat == 3'b000, "R9", "status after reset", line_stat, 0);
        wait_ticks(4);

        // plain characters, tick-paced
        send_char(8'hA5, 1'b1);
        @(negedge clk);
        chk(line_stat[0] == 1'b1, "R1", "ready after tick-timed frame", line_stat[0], 1);
        chk(line_stat[0] == 1'b1, "R4", "ready set", line_stat[0], 1);
        do_read("R5");
        send_char(8'h3C, 1'b1); do_read("R5");
        send_char(8'h00, 1'b1); do_read("R5");
        send_char(8'hFF, 1'b1); do_read("R5");
        send_char(8'h81, 1'b1);
        @(negedge clk);
        chk(rd_data == 8'h81, "R4", "holding register", rd_data, 8'h81);
        do_read("R5");

        // false starts, short and near the check point
        glitch(3);
        glitch(6);
        send_char(8'h5A, 1'b1); do_read("R2");

        // framing error set, then cleared by a good stop bit; a read leaves it
        send_char(8'hC3, 1'b0);
        @(negedge clk);
        chk(line_stat[2] == 1'b1, "R6", "framing set", line_stat[2], 1);
        do_read("R5");
        chk(line_stat[2] == 1'b1, "R6", "framing kept over read", line_stat[2], 1);
        send_char(8'h11, 1'b1);
        @(negedge clk);
        chk(line_stat[2] == 1'b0, "R6", "framing cleared", line_stat[2], 0);
        do_read("R5");

        // overrun
        send_char(8'h12, 1'b1);
        send_char(8'h34, 1'b1);
        @(negedge clk);
        chk(line_stat[1] == 1'b1, "R7", "overrun set", line_stat[1], 1);
        chk(rd_data == 8'h34, "R7", "overwritten byte", rd_data, 8'h34);
        do_read("R7");

        // load meets a read held high
        @(negedge clk) rd_strobe = 1'b1;
        send_char(8'h99, 1'b1);
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
        chk(line_stat[1] == 1'b0, "R8", "no overrun on load with read", line_stat[1], 0);
        chk(rd_data == 8'h99, "R8", "byte loaded under read", rd_data, 8'h99);

        wait_ticks(4);
        chk(exp_q.size() == 0, "R8", "characters not seen", exp_q.size(), 0);
        finish_run();
    end

endmodule